// File: doc/BRIEF.md
# Loopback Capture FIFO with Count Append

This block keeps the tail end of a packet that returns over a diagnostic loopback receive path. It has eight byte-wide entries arranged as a ring. Each new packet starts writing at entry 0. When the write position passes the last entry it wraps to entry 0 and overwrites what was there. Only the most recent eight bytes survive.

When the packet's final byte is written, the block stores three more bytes in the following ring locations: the low byte of the 16-bit received byte count, then the high byte, then the high byte again. The read pointer is then set to the entry after these three bytes. Eight consecutive host reads therefore return the surviving bytes from oldest to newest.

The host reads through one byte-wide port using an active-low strobe that is asynchronous to the bus clock. The rising edge of the strobe passes through a two-flop synchronizer and is edge-detected before the read pointer steps. If the host starts another read before that step is done, the block raises a wait signal until the step completes. The port works only while loopback mode is enabled.

Top module: `lb_capture_fifo`

## Requirements
- R1: The ring has 8 entries. The first byte of a packet is written to entry 0, and each later byte goes to the next entry, wrapping from 7 back to 0.
- R2: On the three clock edges after the edge that takes the final byte (marked by eop_i with byte_valid_i), the block writes three bytes into the next three ring locations, in this order: count bits [7:0], count bits [15:8], count bits [15:8] again.
- R3: The received count is 16 bits wide. It restarts at 1 on a packet's first byte and counts every byte taken, including trailing CRC bytes.
- R4: When the append finishes, the read pointer addresses the entry after the third count byte. Eight reads then return the ring contents from oldest to newest, and a ninth read wraps to the oldest again.
- R5: The read pointer steps by one after each completed read (rd_n_i rising). The step happens on the third rising clock edge after the rise. Until then, rd_data_o holds its value.
- R6: wait_o is high when rd_n_i is low while the step from the previous read is still pending. It drops on the edge at which that step takes place.
- R7: While loopback_en_i is low, rd_data_o is zero, wait_o is low, and strobes do not move the read pointer.
- R8: While loopback_en_i is low, received bytes and eop_i are ignored. Bytes presented during the three append cycles are also ignored.
- R9: A new packet's first byte restarts the write position and the count. The read pointer keeps its value until that packet's append is complete.
- R10: After reset, every entry and the read pointer are zero, and wait_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loopback_en_i | input | 1 | Loopback mode enable |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_data_i | input | 8 | Received byte |
| eop_i | input | 1 | Marks the final byte of the packet |
| rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| rd_data_o | output | 8 | Byte at the read pointer |
| wait_o | output | 1 | Host wait request |

## Verification
The assertions check, on every cycle, these properties:
- write addresses step one at a time, with wrap, within a packet;
- the two high count bytes are equal;
- the count restarts at 1 on a packet's first byte;
- the read pointer moves only on a synchronized step or a load, and never while loopback mode is off;
- the pointer load after the append lands one entry past the last append write;
- each synchronized step is a single-cycle pulse.

Only the bench scenarios can show the data side:
- the actual ring contents seen through the port after short packets, wrapping packets and a packet longer than 255 bytes;
- that stale entries from an earlier packet appear;
- the wait timing when a read is restarted early;
- that input during the append and while loopback mode is off is dropped.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  typedef enum logic [2:0] {
    WR_IDLE,
    WR_RX,
    WR_CNT_LO,
    WR_CNT_HI,
    WR_CNT_HI2
  } wr_state_e;
endpackage

// File: rtl/lbf_ring.sv
module lbf_ring #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_addr_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [DW-1:0]            rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == $clog2(DEPTH)'(i)) mem_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/lbf_wr_ctrl.sv
module lbf_wr_ctrl
  import lbf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enable_i,
  input  logic                     byte_valid_i,
  input  logic [DW-1:0]            byte_data_i,
  input  logic                     eop_i,
  output logic                     wr_en_o,
  output logic [$clog2(DEPTH)-1:0] wr_addr_o,
  output logic [DW-1:0]            wr_data_o,
  output logic                     load_o,
  output logic [$clog2(DEPTH)-1:0] load_ptr_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = 2 * DW;

  wr_state_e st_q, st_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          take, pkt_start;

  assign take = enable_i && byte_valid_i;

  always_comb begin
    st_d      = st_q;
    wptr_d    = wptr_q;
    cnt_d     = cnt_q;
    wr_en_o   = 1'b0;
    wr_addr_o = wptr_q;
    wr_data_o = byte_data_i;
    load_o    = 1'b0;
    pkt_start = 1'b0;
    unique case (st_q)
      WR_IDLE: if (take) begin
        pkt_start = 1'b1;
        wr_en_o   = 1'b1;
        wr_addr_o = '0;
        wptr_d    = AW'(1);
        cnt_d     = CW'(1);
        st_d      = eop_i ? WR_CNT_LO : WR_RX;
      end
      WR_RX: if (take) begin
        wr_en_o = 1'b1;
        wptr_d  = wptr_q + 1'b1;
        cnt_d   = cnt_q + 1'b1;
        if (eop_i) st_d = WR_CNT_LO;
      end
      WR_CNT_LO: begin
        wr_en_o   = 1'b1;
        wr_data_o = cnt_q[DW-1:0];
        wptr_d    = wptr_q + 1'b1;
        st_d      = WR_CNT_HI;
      end
      WR_CNT_HI: begin
        wr_en_o   = 1'b1;
        wr_data_o = cnt_q[CW-1:DW];
        wptr_d    = wptr_q + 1'b1;
        st_d      = WR_CNT_HI2;
      end
      WR_CNT_HI2: begin
        wr_en_o   = 1'b1;
        wr_data_o = cnt_q[CW-1:DW];
        wptr_d    = wptr_q + 1'b1;
        load_o    = 1'b1;
        st_d      = WR_IDLE;
      end
      default: st_d = WR_IDLE;
    endcase
  end

  assign load_ptr_o = wptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WR_IDLE;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // R1: consecutive writes of one packet move by one entry, wrapping
  p_addr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !pkt_start && $past(wr_en_o)) |-> wr_addr_o == $past(wr_addr_o) + 1'b1);

  // R2: both high count bytes are equal
  p_hi_dup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WR_CNT_HI2) |-> wr_data_o == $past(wr_data_o));

  // R3: count restarts on the first byte of a packet
  p_cnt_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start |=> cnt_q == CW'(1));
endmodule

// File: rtl/lbf_rd_sync.sv
module lbf_rd_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_n_i,
  output logic adv_o,
  output logic busy_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rd_n_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // s2/s3 are the synchronized level; rising edge ends a read
  assign adv_o  = s2_q & ~s3_q;
  // rise seen but pointer step not yet taken
  assign busy_o = (s1_q & ~s2_q) | (s2_q & ~s3_q);

  // R5: one step per synchronized rise
  p_adv_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> !adv_o);

  // R6: pending state clears once the step is taken
  p_busy_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && !s1_q) |=> !busy_o);
endmodule

// File: rtl/lb_capture_fifo.sv
module lb_capture_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          loopback_en_i,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] byte_data_i,
  input  logic          eop_i,
  input  logic          rd_n_i,
  output logic [DW-1:0] rd_data_o,
  output logic          wait_o
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_en, load_en, adv_raw, adv, busy;
  logic [AW-1:0] wr_addr, load_ptr, rptr_q;
  logic [DW-1:0] wr_data, ring_data;

  lbf_wr_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (loopback_en_i),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .eop_i        (eop_i),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .load_o       (load_en),
    .load_ptr_o   (load_ptr)
  );

  lbf_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rptr_q),
    .rd_data_o (ring_data)
  );

  lbf_rd_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_n_i (rd_n_i),
    .adv_o  (adv_raw),
    .busy_o (busy)
  );

  assign adv = adv_raw & loopback_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rptr_q <= '0;
    else if (load_en) rptr_q <= load_ptr;
    else if (adv)     rptr_q <= rptr_q + 1'b1;
  end

  assign rd_data_o = loopback_en_i ? ring_data : '0;
  assign wait_o    = loopback_en_i & ~rd_n_i & busy;

  // R5: pointer moves only on a step or a load
  p_ptr_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rptr_q) |-> $past(adv || load_en));

  // R7: no step while loopback is off
  p_ptr_hold_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loopback_en_i && !load_en) |=> $stable(rptr_q));

  // R4: load points just past the last append write
  p_load_pos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> rptr_q == $past(wr_addr) + 1'b1);
endmodule

// File: tb/lb_capture_fifo_test.sv
`timescale 1ns/1ps
module lb_capture_fifo_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lb_en = 1'b0;
  logic       bv = 1'b0;
  logic [7:0] bd = '0;
  logic       eop = 1'b0;
  logic       rd_n = 1'b1;
  logic [7:0] rd_data;
  logic       wt;

  int n_chk = 0, n_bad = 0;
  int ring[8];
  int wp = 0, mrp = 0, mcnt = 0;

  always #2.5 clk = ~clk;

  lb_capture_fifo uut (
    .clk_i(clk), .rst_ni(rst_ni), .loopback_en_i(lb_en), .byte_valid_i(bv),
    .byte_data_i(bd), .eop_i(eop), .rd_n_i(rd_n), .rd_data_o(rd_data), .wait_o(wt)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bytes(int n, int seed, bit fresh, bit last_eop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bv = 1'b1;
      bd = 8'((seed + i * 7) & 255);
      eop = last_eop && (i == n - 1);
      @(posedge clk);
      if (lb_en) begin
        if (fresh && i == 0) begin wp = 0; mcnt = 0; end
        ring[wp] = int'(bd);
        wp = (wp + 1) % 8;
        mcnt = (mcnt + 1) & 16'hffff;
      end
    end
    @(negedge clk);
    bv = 1'b0;
    eop = 1'b0;
  endtask

  // bytes presented during append must be dropped (R8)
  task automatic finish_append(bit stray);
    if (stray) begin
      bv = 1'b1;
      bd = 8'hEE;
      @(negedge clk);
      bv = 1'b0;
    end
    repeat (4) @(negedge clk);
    if (lb_en) begin
      ring[wp] = mcnt & 255;        wp = (wp + 1) % 8;
      ring[wp] = (mcnt >> 8) & 255; wp = (wp + 1) % 8;
      ring[wp] = (mcnt >> 8) & 255; wp = (wp + 1) % 8;
      mrp = wp;
    end
  endtask

  task automatic do_read(string req);
    rd_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rd_data == 8'(ring[mrp]), req, rd_data, ring[mrp]);
    check(wt == 1'b0, {req, " wait"}, wt, 0);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    mrp = (mrp + 1) % 8;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ring[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    lb_en = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(rd_data == 8'd0, "R10 data", rd_data, 0);
    check(wt == 1'b0, "R10 wait", wt, 0);

    // R1 R2 R3 R4: 64-byte packet wraps many times, stray byte during append
    send_bytes(64, 3, 1'b1, 1'b1);
    finish_append(1'b1);
    for (int k = 0; k < 8; k++) do_read("R4 64-byte");
    do_read("R4 ninth read wraps");

    // R2 R3: 300-byte packet, upper count nonzero
    send_bytes(300, 11, 1'b1, 1'b1);
    finish_append(1'b0);
    for (int k = 0; k < 8; k++) do_read("R3 count 300");

    // R1: short packet, stale entries survive
    send_bytes(3, 100, 1'b1, 1'b1);
    finish_append(1'b0);
    for (int k = 0; k < 8; k++) do_read("R1 short packet");

    // R6: restart read early, wait must assert then release on the step
    rd_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rd_data == 8'(ring[mrp]), "R6 first read", rd_data, ring[mrp]);
    rd_n = 1'b1;
    @(negedge clk);
    rd_n = 1'b0;
    #0.5;
    check(wt == 1'b1, "R6 wait after A", wt, 1);
    @(negedge clk);
    check(wt == 1'b1, "R6 wait after B", wt, 1);
    check(rd_data == 8'(ring[mrp]), "R5 held before step", rd_data, ring[mrp]);
    @(negedge clk);
    mrp = (mrp + 1) % 8;
    check(wt == 1'b0, "R6 wait released", wt, 0);
    check(rd_data == 8'(ring[mrp]), "R5 stepped", rd_data, ring[mrp]);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    mrp = (mrp + 1) % 8;
    do_read("R5 after early read");

    // R7: loopback off, port reads zero, strobes ignored
    lb_en = 1'b0;
    @(negedge clk);
    check(rd_data == 8'd0, "R7 data zero", rd_data, 0);
    rd_n = 1'b0;
    repeat (2) @(negedge clk);
    check(wt == 1'b0, "R7 wait low", wt, 0);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: bytes ignored while off
    send_bytes(5, 200, 1'b1, 1'b1);
    finish_append(1'b0);
    lb_en = 1'b1;
    @(negedge clk);
    do_read("R7 pointer unmoved");
    do_read("R8 ring untouched");

    // R9: new packet leaves the read pointer until its append is done
    send_bytes(2, 50, 1'b1, 1'b0);
    do_read("R9 mid-packet pointer kept");
    send_bytes(2, 60, 1'b0, 1'b1);
    finish_append(1'b0);
    for (int k = 0; k < 8; k++) do_read("R9 after append");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule